// File: doc/BRIEF.md
# Discarded-Read No-Operation Sequencer

This block carries out the multi-byte no-operation instructions of an 8-bit processor core. Once the opcode byte has been fetched, the core hands the sequencer the opcode, up to two operand bytes and the current X index. The sequencer then owns the read-only memory port until the instruction ends. It issues exactly the reads that the instruction makes on real hardware and throws away the returned data. No processor register or flag is touched.

The exact read pattern matters because a read of a memory-mapped peripheral can have side effects. The immediate-skip forms make no data read. The zero-page indexed form reads the base address first and then the indexed address, which wraps within page zero. The absolute indexed form makes an extra read at the wrong page when the index carries out of the low address byte. That extra read uses the un-incremented high byte, and the correct read follows one cycle later.

Cycle numbering: the cycle in which `start` is sampled high is cycle 0, which is the opcode fetch. The sequencer is busy from cycle 1 through the instruction's last cycle, N-1, where N is the instruction's documented cycle count.

Top module: `nop_read_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `mem_rd` are all low.
- R2: Opcodes 0x80, 0x82, 0x89, 0xC2 and 0xE2 (2 cycles) keep `busy` high for cycle 1 only, pulse `done` in cycle 1, and never raise `mem_rd`.
- R3: Opcodes 0x04, 0x44 and 0x64 (3 cycles) make one read, in cycle 2, at address {0x00, operand low byte}, with `done` in cycle 2.
- R4: Opcodes 0x14, 0x34, 0x54, 0x74, 0xD4 and 0xF4 (4 cycles) read {0x00, d} in cycle 2 and then {0x00, (d+X) mod 256} in cycle 3, with `done` in cycle 3.
- R5: Opcode 0x0C (4 cycles) makes one read, in cycle 3, at {operand high, operand low}, with `done` in cycle 3.
- R6: Opcodes 0x1C, 0x3C, 0x5C, 0x7C, 0xDC and 0xFC with low byte + X <= 255 take 4 cycles: one read, in cycle 3, at the 16-bit base plus X, with `done` in cycle 3.
- R7: For the R6 opcodes with low byte + X > 255, the instruction takes 5 cycles. Cycle 3 reads {high, (low+X) mod 256}. Cycle 4 reads that address plus 0x100, modulo 2^16. `done` comes in cycle 4.
- R8: `start` is ignored while `busy` is high, including in the `done` cycle. The running sequence is unchanged.
- R9: `start` with any opcode not listed in R2 to R7 is ignored: `busy` stays low and no read is made.
- R10: Each read lasts one cycle, and the address is valid in that cycle. `done` is high only in the last busy cycle, and `busy` falls in the next cycle. Operand and index inputs are sampled only in cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the instruction in `opcode`; sampled only when idle |
| opcode | input | 8 | Fetched opcode byte |
| opnd_lo | input | 8 | First operand byte (immediate, zero-page address, or low address byte) |
| opnd_hi | input | 8 | Second operand byte (high address byte); unused by 2-byte forms |
| index_x | input | 8 | Current X index value |
| busy | output | 1 | High from cycle 1 through the instruction's last cycle |
| done | output | 1 | One-cycle pulse in the last cycle |
| mem_addr | output | 16 | Read address, valid when `mem_rd` is high |
| mem_rd | output | 1 | One-cycle read strobe; returned data is discarded |

## Verification
An internal fault appears at the ports within at most four cycles of `start`. A wrong step count or wrong form shows up as a read strobe in the wrong cycle, or as `done` and `busy` ending one cycle early or late. A wrong operand or index register shows up as a wrong address on the first read that uses it. The carry case has a distinctive signature: a missing or misplaced page-crossing read changes both the number of strobes and the length of the instruction. Sweeping every opcode over index and low-byte values on both sides of the carry boundary therefore exposes the fault in the same instruction that triggers it.

// File: rtl/nop_read_sequencer.sv
module nop_read_sequencer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  index_x,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic        mem_rd
);

  typedef enum logic [2:0] {
    F_NONE, F_IMM, F_ZP, F_ZPX, F_ABS, F_ABSX
  } form_t;

  form_t       form_d, form_q;
  logic        busy_q;
  logic [2:0]  step_q;
  logic [2:0]  last_step;
  logic [7:0]  lo_q, hi_q, x_q;
  logic [8:0]  sum;
  logic        carry;

  always_comb begin
    case (opcode)
      8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2:               form_d = F_IMM;
      8'h04, 8'h44, 8'h64:                             form_d = F_ZP;
      8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4:        form_d = F_ZPX;
      8'h0C:                                           form_d = F_ABS;
      8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC:        form_d = F_ABSX;
      default:                                         form_d = F_NONE;
    endcase
  end

  assign sum   = {1'b0, lo_q} + {1'b0, x_q};
  assign carry = sum[8];

  always_comb begin
    case (form_q)
      F_IMM:   last_step = 3'd1;
      F_ZP:    last_step = 3'd2;
      F_ZPX:   last_step = 3'd3;
      F_ABS:   last_step = 3'd3;
      F_ABSX:  last_step = carry ? 3'd4 : 3'd3;
      default: last_step = 3'd1;
    endcase
  end

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = 16'h0000;
    if (busy_q) begin
      case (form_q)
        F_ZP:
          if (step_q == 3'd2) begin
            mem_rd   = 1'b1;
            mem_addr = {8'h00, lo_q};
          end
        F_ZPX:
          if (step_q == 3'd2) begin
            mem_rd   = 1'b1;
            mem_addr = {8'h00, lo_q};
          end else if (step_q == 3'd3) begin
            mem_rd   = 1'b1;
            mem_addr = {8'h00, sum[7:0]};
          end
        F_ABS:
          if (step_q == 3'd3) begin
            mem_rd   = 1'b1;
            mem_addr = {hi_q, lo_q};
          end
        F_ABSX:
          if (step_q == 3'd3) begin
            mem_rd   = 1'b1;
            mem_addr = {hi_q, sum[7:0]};
          end else if (step_q == 3'd4) begin
            mem_rd   = 1'b1;
            mem_addr = {hi_q + 8'h01, sum[7:0]};
          end
        default: ;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (step_q == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= 3'd0;
      form_q <= F_NONE;
      lo_q   <= 8'h00;
      hi_q   <= 8'h00;
      x_q    <= 8'h00;
    end else if (!busy_q) begin
      if (start && form_d != F_NONE) begin
        busy_q <= 1'b1;
        step_q <= 3'd1;
        form_q <= form_d;
        lo_q   <= opnd_lo;
        hi_q   <= opnd_hi;
        x_q    <= index_x;
      end
    end else if (done) begin
      busy_q <= 1'b0;
      step_q <= 3'd0;
    end else begin
      step_q <= step_q + 3'd1;
    end
  end

endmodule

module nop_read_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  opcode,
  input logic [7:0]  opnd_lo,
  input logic [7:0]  opnd_hi,
  input logic [7:0]  index_x,
  input logic        busy,
  input logic        done,
  input logic [15:0] mem_addr,
  input logic        mem_rd
);

  function automatic logic is_imm(input logic [7:0] o);
    return o == 8'h80 || o == 8'h82 || o == 8'h89 || o == 8'hC2 || o == 8'hE2;
  endfunction
  function automatic logic is_zp(input logic [7:0] o);
    return o == 8'h04 || o == 8'h44 || o == 8'h64;
  endfunction
  function automatic logic is_zpx(input logic [7:0] o);
    return o[4:0] == 5'h14 && (o[7:5] != 3'd4 && o[7:5] != 3'd5);
  endfunction
  function automatic logic is_absx(input logic [7:0] o);
    return o[4:0] == 5'h1C && (o[7:5] != 3'd4 && o[7:5] != 3'd5);
  endfunction
  function automatic logic known(input logic [7:0] o);
    return is_imm(o) || is_zp(o) || is_zpx(o) || is_absx(o) || o == 8'h0C;
  endfunction

  logic       accept;
  logic [7:0] op_q;
  logic       unused_ok;
  assign accept    = start && !busy;
  assign unused_ok = ^{opnd_hi, index_x};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) op_q <= 8'h00;
    else if (accept && known(opcode)) op_q <= opcode;

  always @(posedge clk)
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!busy && !done && !mem_rd && !unused_ok | unused_ok);
    end

  a_r2_imm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_imm(opcode) |=> done && busy && !mem_rd);

  a_r3_zp_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && busy && (is_zp(op_q) || is_zpx(op_q)) |-> mem_addr[15:8] == 8'h00);

  a_r4_zpx_base_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_zpx(opcode) |=> ##1 mem_rd && mem_addr == {8'h00, $past(opnd_lo, 2)});

  a_r7_second_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) && is_absx(op_q) |-> mem_addr == $past(mem_addr) + 16'h0100);

  a_r8_busy_holds_op: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(op_q));

  a_r9_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !known(opcode) |=> !busy && !mem_rd);

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

endmodule

bind nop_read_sequencer nop_read_sequencer_chk u_chk (.*);

// File: tb/tb_nop_read_sequencer.sv
module tb_nop_read_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00, opnd_lo = 8'h00, opnd_hi = 8'h00, index_x = 8'h00;
  logic        busy, done, mem_rd;
  logic [15:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nop_read_sequencer dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // form: 0 none, 1 imm, 2 zp, 3 zpx, 4 abs, 5 absx
  function automatic int form_of(input logic [7:0] o);
    case (o)
      8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2: return 1;
      8'h04, 8'h44, 8'h64: return 2;
      8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4: return 3;
      8'h0C: return 4;
      8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int f, input int lo, input int x);
    case (f)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return (lo + x > 255) ? "R7" : "R6";
      default: return "R9";
    endcase
  endfunction

  // Run one instruction and compare cycles 1..6 with the arithmetic expectation.
  task automatic run(input logic [7:0] op, input int lo, input int hi, input int x,
                     input bit poke_start);
    int f, last, s;
    string rq;
    f    = form_of(op);
    s    = lo + x;
    rq   = req_of(f, lo, x);
    last = (f == 1) ? 1 : (f == 2) ? 2 : (f == 5 && s > 255) ? 4 : (f == 0) ? 0 : 3;
    @(negedge clk);
    start = 1'b1; opcode = op; opnd_lo = lo[7:0]; opnd_hi = hi[7:0]; index_x = x[7:0];
    for (int k = 1; k <= 6; k++) begin
      bit e_rd;
      int e_addr;
      @(negedge clk);
      start   = poke_start && k <= last;
      opcode  = 8'h0C;
      opnd_lo = ~lo[7:0]; opnd_hi = ~hi[7:0]; index_x = ~x[7:0];
      e_rd = 0; e_addr = 0;
      if (f == 2 && k == 2) begin e_rd = 1; e_addr = lo; end
      if (f == 3 && k == 2) begin e_rd = 1; e_addr = lo; end
      if (f == 3 && k == 3) begin e_rd = 1; e_addr = s & 255; end
      if (f == 4 && k == 3) begin e_rd = 1; e_addr = hi * 256 + lo; end
      if (f == 5 && k == 3) begin e_rd = 1; e_addr = hi * 256 + (s & 255); end
      if (f == 5 && k == 4 && s > 255) begin e_rd = 1; e_addr = (hi * 256 + s) & 16'hFFFF; end
      check(busy == (k <= last), {rq, poke_start ? "/R8" : "", " busy"}, busy, k <= last);
      check(done == (k == last), {rq, "/R10 done"}, done, k == last);
      check(mem_rd == e_rd, {rq, " strobe"}, mem_rd, e_rd);
      if (e_rd) check(mem_addr == e_addr[15:0], {rq, " address"}, mem_addr, e_addr);
    end
    start = 1'b0;
  endtask

  initial begin
    int xs [6] = '{0, 1, 16, 127, 128, 255};
    int los[6] = '{0, 1, 127, 128, 254, 255};
    int his[2] = '{8'h12, 8'hFF};
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd, "R1 reset", {busy, done, mem_rd}, 0);
    start = 1'b1; opcode = 8'h04;
    @(negedge clk);
    check(!busy && !mem_rd, "R1 start held in reset", {busy, mem_rd}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R2..R7 sweep over all supported opcodes
    for (int o = 0; o < 256; o++) begin
      if (form_of(o[7:0]) != 0) begin
        foreach (los[i]) foreach (xs[j]) foreach (his[h])
          run(o[7:0], los[i], his[h], xs[j], 1'b0);
        for (int x = 0; x < 256; x += 5) run(o[7:0], 8'hC3, 8'h40, x, 1'b0);
      end
    end
    // R8: start pokes during busy
    run(8'h64, 8'h33, 8'h00, 8'h05, 1'b1);
    run(8'h14, 8'hF0, 8'h00, 8'h20, 1'b1);
    run(8'hFC, 8'hF0, 8'hFF, 8'h20, 1'b1);
    run(8'h89, 8'h55, 8'h00, 8'h00, 1'b1);
    // R9: every unsupported opcode
    for (int o = 0; o < 256; o++)
      if (form_of(o[7:0]) == 0) run(o[7:0], 8'h10, 8'h20, 8'h30, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule